// File: doc/BRIEF.md
# Multi-drop serial receiver with sleep and wake

This block receives asynchronous serial characters on a single line that idles high. The line is oversampled by a tick that runs at sixteen times the bit rate. A character is a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. Three samples taken in the middle of each bit are combined by a majority vote to give the bit's value. If the three samples do not all agree, the character is marked as noisy. A completed character is moved in one step from the shift register into a holding register. The next character can therefore arrive while software has not yet read the previous one.

On a bus with several receivers, software can put the receiver to sleep once it has decided that the current message is addressed to another node. While the receiver sleeps, no receive flag can be set. Hardware ends the sleep by itself in one of two ways, chosen by a mode input. In the first mode, the receiver wakes when the line has stayed idle for a full character time. In the second mode, it wakes when a character arrives whose top data bit is 1, and that character is then delivered as usual. Software can also end the sleep directly.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, every flag and the sleep bit read 0. In 8-bit mode (`nine_i`=0), a frame made of a 0 start bit, eight data bits sent least significant bit first and a 1 stop bit is delivered on `rx_data_o[7:0]`, with `rx_data_o[8]`=0, and `ready_o` rises.
- R2: With `nine_i`=1, nine data bits are received and delivered on `rx_data_o[8:0]`.
- R3: Each bit is the majority vote of the samples taken at ticks 7, 8 and 9 of its 16-tick period. A single sample that differs from the others does not change the value, but it sets `noise_o` together with `ready_o`.
- R4: A stop bit that votes 0 sets `ferr_o` together with `ready_o`.
- R5: A low pulse on the line whose start-bit vote is 1 is discarded. It produces no character and no flag.
- R6: If a character completes while `ready_o` is 1, `overrun_o` is set, `rx_data_o` keeps the older character and the new character is lost.
- R7: A `data_rd_i` strobe clears `ready_o`. `overrun_o`, `noise_o`, `ferr_o` and `idle_o` are cleared only by a `stat_rd_i` strobe followed by a `data_rd_i` strobe. A data read on its own leaves them set.
- R8: `idle_o` is set once, when the line has been high for a full frame time (10 or 11 bit periods) after at least one received character, and only while the receiver is awake.
- R9: While `sleep_o` is 1, `ready_o`, `overrun_o`, `noise_o`, `ferr_o` and `idle_o` cannot become set. A `sleep_set_i` strobe sets `sleep_o`.
- R10: With `addr_wake_i`=0, a sleeping receiver clears `sleep_o` after the line has been idle for a full frame time. The next frame is then received normally.
- R11: With `addr_wake_i`=1, a character whose top bit is 1 clears `sleep_o` and is delivered normally. The top bit is bit 7 in 8-bit mode and bit 8 in 9-bit mode. Other characters are ignored, and idle time does not wake the receiver.
- R12: A `sleep_clr_i` strobe clears `sleep_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, high when idle |
| tick16_i | input | 1 | One-cycle enable pulse at 16 times the bit rate |
| nine_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| addr_wake_i | input | 1 | 1 selects wake on the top data bit, 0 selects wake on idle line |
| sleep_set_i | input | 1 | Strobe that puts the receiver to sleep |
| sleep_clr_i | input | 1 | Strobe that wakes the receiver under software control |
| stat_rd_i | input | 1 | Status-read strobe; arms the clearing of the error flags |
| data_rd_i | input | 1 | Data-read strobe |
| rx_data_o | output | 9 | Holding register contents |
| ready_o | output | 1 | Character ready |
| idle_o | output | 1 | Line has gone idle after a character |
| overrun_o | output | 1 | A character was lost |
| noise_o | output | 1 | Sample disagreement in the delivered character |
| ferr_o | output | 1 | Stop bit read as 0 |
| sleep_o | output | 1 | Receiver sleep bit |

## Verification
The assertions assume that `tick16_i` is a pulse one clock wide, that the read strobes are one clock wide, and that `nine_i` and `addr_wake_i` change only while the line is idle. The bench produces the tick from a free-running divide-by-4 counter. It changes the line only on tick boundaries and holds every bit for exactly 16 ticks, apart from deliberate single-tick glitches. It changes the mode inputs only between frames, after a full idle bit. Idle-line wake depends on there being no gap between frames within a message. The bench therefore starts each following frame within two bit times, and it waits at least twelve bit times wherever an idle period is intended.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
  localparam int DW = 9;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_st_e;
endpackage

// File: rtl/mdrop_rx_rstsync.sv
module mdrop_rx_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) pipe_q <= '0;
    else          pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
  import mdrop_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rxs_i,
  input  logic          nine_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          msb_o,
  output logic          noise_o,
  output logic          ferr_o,
  output logic          busy_o
);
  localparam int PHW = $clog2(OSR);
  localparam logic [PHW-1:0] PH_A   = PHW'(OSR/2 - 1);
  localparam logic [PHW-1:0] PH_B   = PHW'(OSR/2);
  localparam logic [PHW-1:0] PH_C   = PHW'(OSR/2 + 1);
  localparam logic [PHW-1:0] PH_END = PHW'(OSR - 1);

  rx_st_e        st_q, st_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic [3:0]    bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [1:0]    smp_q, smp_d;
  logic          nz_q, nz_d;
  logic          vote, dis;
  logic [3:0]    last_bit;

  // majority of the two stored mid-bit samples and the current one
  always_comb begin
    vote     = (smp_q[0] & smp_q[1]) | (smp_q[0] & rxs_i) | (smp_q[1] & rxs_i);
    dis      = !((smp_q[0] == smp_q[1]) && (smp_q[1] == rxs_i));
    last_bit = nine_i ? 4'd8 : 4'd7;
  end

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    smp_d   = smp_q;
    nz_d    = nz_q;
    done_o  = 1'b0;
    ferr_o  = 1'b0;
    noise_o = 1'b0;
    if (tick_i) begin
      if (st_q == ST_IDLE) begin
        if (!rxs_i) begin
          st_d = ST_START;
          ph_d = PHW'(1);
          nz_d = 1'b0;
        end
      end else begin
        ph_d = (ph_q == PH_END) ? '0 : ph_q + PHW'(1);
        if (ph_q == PH_A) smp_d[0] = rxs_i;
        if (ph_q == PH_B) smp_d[1] = rxs_i;
        if (ph_q == PH_C) begin
          case (st_q)
            ST_START: begin
              if (vote) st_d = ST_IDLE;
              else      nz_d = dis;
            end
            ST_DATA: begin
              sh_d = {vote, sh_q[DW-1:1]};
              nz_d = nz_q | dis;
            end
            ST_STOP: begin
              done_o  = 1'b1;
              ferr_o  = !vote;
              noise_o = nz_q | dis;
              st_d    = ST_IDLE;
            end
            default: ;
          endcase
        end
        if (ph_q == PH_END) begin
          if (st_q == ST_START) begin
            st_d  = ST_DATA;
            bit_d = 4'd0;
          end else if (st_q == ST_DATA) begin
            if (bit_q == last_bit) st_d = ST_STOP;
            else                   bit_d = bit_q + 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      smp_q <= '1;
      nz_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      smp_q <= smp_d;
      nz_q  <= nz_d;
    end
  end

  assign data_o = nine_i ? sh_q : {1'b0, sh_q[DW-1:1]};
  assign msb_o  = sh_q[DW-1];
  assign busy_o = (st_q != ST_IDLE);

  // R3: a completed frame only comes out of the stop-bit vote point
  a_r3_done_at_vote: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> tick_i && (ph_q == PH_C));
endmodule

// File: rtl/mdrop_rx_idle.sv
module mdrop_rx_idle #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rxs_i,
  input  logic busy_i,
  input  logic nine_i,
  output logic idle_o
);
  localparam int CW = $clog2(11*OSR + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len;
  logic          high;

  always_comb begin
    len    = nine_i ? CW'(11*OSR) : CW'(10*OSR);
    high   = rxs_i && !busy_i;
    cnt_d  = cnt_q;
    idle_o = 1'b0;
    if (!high) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q < len)) begin
      cnt_d  = cnt_q + CW'(1);
      idle_o = (cnt_q == len - CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: idle is only reported while the line is high and no frame is running
  a_r8_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(rxs_i) || rxs_i);
endmodule

// File: rtl/mdrop_rx_flags.sv
module mdrop_rx_flags
  import mdrop_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] frm_data_i,
  input  logic          frm_msb_i,
  input  logic          frm_nz_i,
  input  logic          frm_fe_i,
  input  logic          idle_pulse_i,
  input  logic          addr_wake_i,
  input  logic          sleep_set_i,
  input  logic          sleep_clr_i,
  input  logic          stat_rd_i,
  input  logic          data_rd_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o,
  output logic          ovr_o,
  output logic          nf_o,
  output logic          fe_o,
  output logic          idl_o,
  output logic          slp_o
);
  logic [DW-1:0] data_q, data_d;
  logic rdy_q, rdy_d, ovr_q, ovr_d, nf_q, nf_d, fe_q, fe_d;
  logic idl_q, idl_d, slp_q, slp_d, seen_q, seen_d, arm_q, arm_d;
  logic addr_hit, idle_hit, awake, accept, ovr_ev, err_clr;

  always_comb begin
    addr_hit = done_i && addr_wake_i && frm_msb_i && slp_q;
    idle_hit = idle_pulse_i && !addr_wake_i && slp_q;
    awake    = !slp_q || addr_hit;
    err_clr  = data_rd_i && arm_q;
    accept   = done_i && awake && !(rdy_q && !data_rd_i);
    ovr_ev   = done_i && awake && rdy_q && !data_rd_i;

    data_d = accept ? frm_data_i : data_q;
    rdy_d  = accept ? 1'b1 : (data_rd_i ? 1'b0 : rdy_q);
    nf_d   = (accept && frm_nz_i) ? 1'b1 : (err_clr ? 1'b0 : nf_q);
    fe_d   = (accept && frm_fe_i) ? 1'b1 : (err_clr ? 1'b0 : fe_q);
    ovr_d  = ovr_ev ? 1'b1 : (err_clr ? 1'b0 : ovr_q);
    idl_d  = (idle_pulse_i && !slp_q && seen_q) ? 1'b1 : (err_clr ? 1'b0 : idl_q);
    seen_d = (done_i && awake) ? 1'b1 : (idle_pulse_i ? 1'b0 : seen_q);
    arm_d  = stat_rd_i ? 1'b1 : (data_rd_i ? 1'b0 : arm_q);
    slp_d  = sleep_set_i ? 1'b1 :
             ((sleep_clr_i || addr_hit || idle_hit) ? 1'b0 : slp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      nf_q   <= 1'b0;
      fe_q   <= 1'b0;
      idl_q  <= 1'b0;
      slp_q  <= 1'b0;
      seen_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      ovr_q  <= ovr_d;
      nf_q   <= nf_d;
      fe_q   <= fe_d;
      idl_q  <= idl_d;
      slp_q  <= slp_d;
      seen_q <= seen_d;
      arm_q  <= arm_d;
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign ovr_o  = ovr_q;
  assign nf_o   = nf_q;
  assign fe_o   = fe_q;
  assign idl_o  = idl_q;
  assign slp_o  = slp_q;

  a_r9_no_ready_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    slp_q && !(done_i && addr_wake_i && frm_msb_i) && !rdy_q |=> !rdy_q);
  a_r9_no_overrun_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    slp_q && !(done_i && addr_wake_i && frm_msb_i) && !ovr_q |=> !ovr_q);
  a_r9_no_idle_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    slp_q && !idl_q |=> !idl_q);
  a_r6_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !slp_q && rdy_q && !data_rd_i |=> ovr_q && $stable(data_q));
  a_r7_ready_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_q) |-> $past(data_rd_i));
  a_r8_idle_after_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idl_q) |-> $past(seen_q && !slp_q));
  // R10, R11, R12: the sleep bit drops only for one of its three causes
  a_r10_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_q) |-> $past(sleep_clr_i || (idle_pulse_i && !addr_wake_i) ||
                           (done_i && addr_wake_i && frm_msb_i)));
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd_i,
  input  logic          tick16_i,
  input  logic          nine_i,
  input  logic          addr_wake_i,
  input  logic          sleep_set_i,
  input  logic          sleep_clr_i,
  input  logic          stat_rd_i,
  input  logic          data_rd_i,
  output logic [DW-1:0] rx_data_o,
  output logic          ready_o,
  output logic          idle_o,
  output logic          overrun_o,
  output logic          noise_o,
  output logic          ferr_o,
  output logic          sleep_o
);
  logic          rst_n_s;
  logic          rxs;
  logic          done, msb, nz, fe, busy, idle_pulse;
  logic [DW-1:0] frm_data;

  mdrop_rx_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  mdrop_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(rxd_i), .q_o(rxs));

  mdrop_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .tick_i(tick16_i), .rxs_i(rxs), .nine_i(nine_i),
    .done_o(done), .data_o(frm_data), .msb_o(msb), .noise_o(nz), .ferr_o(fe),
    .busy_o(busy));

  mdrop_rx_idle #(.OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_n_s), .tick_i(tick16_i), .rxs_i(rxs), .busy_i(busy),
    .nine_i(nine_i), .idle_o(idle_pulse));

  mdrop_rx_flags u_flags (
    .clk(clk), .rst_n(rst_n_s), .done_i(done), .frm_data_i(frm_data),
    .frm_msb_i(msb), .frm_nz_i(nz), .frm_fe_i(fe), .idle_pulse_i(idle_pulse),
    .addr_wake_i(addr_wake_i), .sleep_set_i(sleep_set_i), .sleep_clr_i(sleep_clr_i),
    .stat_rd_i(stat_rd_i), .data_rd_i(data_rd_i), .data_o(rx_data_o),
    .rdy_o(ready_o), .ovr_o(overrun_o), .nf_o(noise_o), .fe_o(ferr_o),
    .idl_o(idle_o), .slp_o(sleep_o));
endmodule

// File: tb/sim_mdrop_rx.sv
`timescale 1ns/1ps
module sim_mdrop_rx;
  typedef struct {
    logic [8:0] d;
    logic       nz;
    logic       fe;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic nine = 1'b0, awake_mode = 1'b0;
  logic s_set = 1'b0, s_clr = 1'b0, st_rd = 1'b0, d_rd = 1'b0;
  logic [1:0] div;
  logic tick;
  logic [8:0] rx_data;
  logic ready, idle, ovr, noise, ferr, sleep;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 1'b0;
  logic rdy_prev = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) div <= 2'd0;
    else        div <= div + 2'd1;
  assign tick = (div == 2'd3);

  mdrop_rx u0 (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .tick16_i(tick), .nine_i(nine),
    .addr_wake_i(awake_mode), .sleep_set_i(s_set), .sleep_clr_i(s_clr),
    .stat_rd_i(st_rd), .data_rd_i(d_rd), .rx_data_o(rx_data), .ready_o(ready),
    .idle_o(idle), .overrun_o(ovr), .noise_o(noise), .ferr_o(ferr), .sleep_o(sleep));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every rising ready pops one expected character
  always @(negedge clk) begin
    if (rst_n && ready && !rdy_prev) begin
      if (q.size() == 0) begin
        check("R9 unexpected character", {23'd0, rx_data}, 32'h1ff);
      end else begin
        exp_t e;
        e = q.pop_front();
        check("R1/R2 data", {23'd0, rx_data}, {23'd0, e.d});
        check("R3 noise flag", {31'd0, noise}, {31'd0, e.nz});
        check("R4 framing flag", {31'd0, ferr}, {31'd0, e.fe});
      end
    end
    rdy_prev = ready;
  end

  task automatic wait_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  task automatic bits(input int n);
    repeat (n * 16) wait_tick();
  endtask

  task automatic bit_out(input logic v, input bit glitch);
    for (int t = 0; t < 16; t++) begin
      rxd = (glitch && t == 8) ? ~v : v;
      wait_tick();
    end
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stop_v,
                      input int gl, input bit expect_rx, input logic e_nz);
    if (expect_rx) begin
      exp_t e;
      e.d  = (nb == 8) ? {1'b0, d[7:0]} : d;
      e.nz = e_nz;
      e.fe = ~stop_v;
      q.push_back(e);
    end
    bit_out(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i], i == gl);
    bit_out(stop_v, 1'b0);
    bit_out(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check("R1 character count", q.size(), 0);
    q.delete();
  endtask

  task automatic strobe_stat();
    @(negedge clk); st_rd = 1'b1; @(negedge clk); st_rd = 1'b0;
  endtask
  task automatic strobe_data();
    @(negedge clk); d_rd = 1'b1; @(negedge clk); d_rd = 1'b0;
  endtask
  task automatic rd_all();
    strobe_stat();
    strobe_data();
  endtask
  task automatic do_sleep();
    @(negedge clk); s_set = 1'b1; @(negedge clk); s_set = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    check("R1 reset ready", {31'd0, ready}, 0);
    check("R1 reset flags", {27'd0, idle, ovr, noise, ferr, sleep}, 0);
    bits(12);

    // R1: 8-bit frames
    send(9'h0A5, 8, 1'b1, -1, 1'b1, 1'b0); rd_all();
    send(9'h03C, 8, 1'b1, -1, 1'b1, 1'b0); rd_all();
    send(9'h000, 8, 1'b1, -1, 1'b1, 1'b0); rd_all();
    send(9'h0FF, 8, 1'b1, -1, 1'b1, 1'b0); rd_all();

    // R2: 9-bit frames
    nine = 1'b1;
    send(9'h1A5, 9, 1'b1, -1, 1'b1, 1'b0); rd_all();
    send(9'h0FF, 9, 1'b1, -1, 1'b1, 1'b0); rd_all();
    send(9'h100, 9, 1'b1, -1, 1'b1, 1'b0); rd_all();
    nine = 1'b0;

    // R3: single-sample glitch -> correct value, noise set
    send(9'h05A, 8, 1'b1, 3, 1'b1, 1'b1);
    rd_all();
    check("R7 noise cleared", {31'd0, noise}, 0);

    // R4: stop bit low
    send(9'h081, 8, 1'b0, -1, 1'b1, 1'b0);
    check("R4 ferr held", {31'd0, ferr}, 1);
    rd_all();
    check("R7 ferr cleared", {31'd0, ferr}, 0);

    // R5: short low pulse is a false start
    rxd = 1'b0; repeat (3) wait_tick(); rxd = 1'b1;
    bits(2);
    check("R5 false start ready", {31'd0, ready}, 0);
    check("R5 false start flags", {29'd0, noise, ferr, ovr}, 0);

    // R6/R7: overrun keeps old data
    send(9'h011, 8, 1'b1, -1, 1'b1, 1'b0);
    send(9'h022, 8, 1'b1, -1, 1'b0, 1'b0);
    check("R6 overrun set", {31'd0, ovr}, 1);
    check("R6 old data kept", {23'd0, rx_data}, 32'h011);
    strobe_data();
    check("R7 ready cleared by data read", {31'd0, ready}, 0);
    check("R7 overrun survives plain read", {31'd0, ovr}, 1);
    rd_all();
    check("R7 overrun cleared", {31'd0, ovr}, 0);

    // R8: idle flag once after a character
    send(9'h044, 8, 1'b1, -1, 1'b1, 1'b0);
    rd_all();
    bits(12);
    check("R8 idle set", {31'd0, idle}, 1);
    rd_all();
    check("R7 idle cleared", {31'd0, idle}, 0);
    bits(12);
    check("R8 idle only once", {31'd0, idle}, 0);

    // R9/R10: idle-line wake
    do_sleep();
    check("R9 sleep set", {31'd0, sleep}, 1);
    send(9'h077, 8, 1'b1, -1, 1'b0, 1'b0);
    check("R9 asleep ready", {31'd0, ready}, 0);
    check("R9 asleep sleep held", {31'd0, sleep}, 1);
    bits(12);
    check("R10 woke on idle", {31'd0, sleep}, 0);
    check("R9 no idle flag while asleep", {31'd0, idle}, 0);
    send(9'h078, 8, 1'b1, -1, 1'b1, 1'b0);
    rd_all();
    do_sleep();
    send(9'h079, 8, 1'b0, -1, 1'b0, 1'b0);
    check("R9 asleep ferr", {31'd0, ferr}, 0);
    check("R9 asleep sleep held 2", {31'd0, sleep}, 1);
    bits(12);
    check("R10 woke again", {31'd0, sleep}, 0);

    // R11: address-mark wake, 8-bit
    awake_mode = 1'b1;
    do_sleep();
    send(9'h012, 8, 1'b1, -1, 1'b0, 1'b0);
    check("R11 msb0 ignored", {31'd0, ready}, 0);
    bits(12);
    check("R11 idle does not wake", {31'd0, sleep}, 1);
    send(9'h092, 8, 1'b1, -1, 1'b1, 1'b0);
    check("R11 msb7 wakes", {31'd0, sleep}, 0);
    rd_all();

    // R11: address-mark wake, 9-bit
    nine = 1'b1;
    do_sleep();
    send(9'h0F0, 9, 1'b1, -1, 1'b0, 1'b0);
    check("R11 bit7 in 9-bit mode ignored", {30'd0, sleep, ready}, 32'h2);
    send(9'h105, 9, 1'b1, -1, 1'b1, 1'b0);
    check("R11 bit8 wakes", {31'd0, sleep}, 0);
    rd_all();
    nine = 1'b0;
    awake_mode = 1'b0;
    bits(2);

    // R12: software wake
    do_sleep();
    check("R12 sleep set", {31'd0, sleep}, 1);
    @(negedge clk); s_clr = 1'b1; @(negedge clk); s_clr = 1'b0;
    check("R12 sleep cleared", {31'd0, sleep}, 0);
    send(9'h033, 8, 1'b1, -1, 1'b1, 1'b0);
    rd_all();

    bits(2);
    finish_run();
  end
endmodule